// File: doc/BRIEF.md
# Dithered Sine Oscillator

This block is a single-channel oscillator that turns a fixed 32-bit phase step into a stream of signed sine samples, one per enabled clock. A 32-bit accumulator adds the step on every enabled cycle and wraps modulo 2^32. Before the phase is cut down to the 12 bits that address the sine path, a small pseudo-random value is added into the bits just below those 12. This spreads the truncation error into noise instead of letting it form spurious tones.

The sine is not read from one large table. The 12-bit phase splits into a 6-bit coarse angle a and a 6-bit fine angle b. Four 64-entry tables give sin(a), cos(a), sin(b) and cos(b). The identity sin(a+b) = sin(a)cos(b) + cos(a)sin(b) then costs two multipliers and an adder. The sum is rounded to 13 bits and clamped so that a full-scale peak cannot wrap.

The step sets the tone as round(f_out / f_clk × 2^32). At a 100 MHz clock, 42,949,673 gives 1 MHz and 429,496,730 gives 10 MHz. The block has no state machine. It is a four-stage pipeline in which every stage advances only when the clock enable is high.

Top module: `nco_dithered`

## Requirements
- R1: During and right after reset, `valid_o` is 0 and `sample_o` is 0.
- R2: The phase of the k-th valid sample (k counted from 0 after reset) is k × `phase_inc_i` modulo 2^32. A step of 0xC0000000 therefore walks backwards through the quarter points.
- R3: The phase is reduced to its upper 12 bits after a pseudo-random dither of 4 bits is added directly below those 12 bits. Each sample lies within 10 codes of 4096·sin(2π·phase/2^32), clamped to the output range.
- R4: `sample_o` is 13-bit two's complement, rounded to nearest and saturated. With a step of 0x40000000 the samples repeat exactly as 0, +4095, 0, −4096. The positive peak clamps to +4095 and never wraps negative.
- R5: The fixed latency is 4 enabled clock edges. After N enabled edges since reset, exactly N−3 valid samples have appeared (none when N < 4).
- R6: An edge with `en_i` low advances nothing. After that edge `valid_o` is 0, `sample_o` keeps its value, and the phase sequence later continues without a gap.
- R7: The dither source is a maximal-length 16-bit LFSR. It is seeded to a nonzero value by reset, runs every clock, and never reaches the all-zero state.
- R8: Once the pipeline is full, every edge with `en_i` high produces exactly one sample, with `valid_o` high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Clock enable: advances the accumulator and every pipeline stage |
| phase_inc_i | input | 32 | Phase step added per enabled cycle |
| sample_o | output | 13 | Signed sine sample |
| valid_o | output | 1 | High for one cycle after each enabled edge that delivers a sample |

## Verification
A corrupted accumulator or step path shows up as a phase error on the next valid sample. That sample drifts away from the ideal sine by far more than the 10-code tolerance, and the error keeps growing sample after sample. A wrong table entry, product or rounding shift shows up on the exact quarter-turn patterns within four enabled edges. A broken stall shows up as a skipped or repeated phase, or as `valid_o` high after a disabled edge, in the very next cycle. A valid chain that is too short or too long changes the count of valid samples from N−3.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded fixed-point sin/cos of the angle idx*2*pi/steps, scaled by scale
    function automatic int trig_code(input int idx, input int steps,
                                     input bit use_cos, input int scale);
        real ang;
        real v;
        ang = TWO_PI * real'(idx) / real'(steps);
        v   = use_cos ? $cos(ang) : $sin(ang);
        v   = v * real'(scale);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
    parameter int          LFSR_W = 16,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          OUT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] dither_o
);
    logic [LFSR_W-1:0] state;

    // Galois form, shifting right; free running on every clock
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LFSR_W'(SEED);
        end else if (state[0]) begin
            state <= (state >> 1) ^ LFSR_W'(TAPS);
        end else begin
            state <= state >> 1;
        end
    end

    assign dither_o = state[OUT_W-1:0];

    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W    = 32,
    parameter int PH_W     = 12,
    parameter int DITHER_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [ACC_W-1:0]    inc,
    input  logic [DITHER_W-1:0] dither,
    output logic [PH_W-1:0]     phase_o,
    output logic                vld_o
);
    // Dither lands directly below the retained phase bits
    localparam int SHIFT = ACC_W - PH_W - DITHER_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] dithered;

    always_comb begin
        dithered = acc + (ACC_W'(dither) << SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            phase_o <= '0;
            vld_o   <= 1'b0;
        end else if (en) begin
            acc     <= acc + inc;
            phase_o <= dithered[ACC_W-1 -: PH_W];
            vld_o   <= 1'b1;
        end
    end

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> $stable(acc));

endmodule

// File: rtl/nco_trig_tables.sv
module nco_trig_tables
    import nco_pkg::*;
#(
    parameter int PH_W     = 12,
    parameter int COARSE_W = 6,
    parameter int TBL_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [PH_W-1:0]         phase_i,
    input  logic                    vld_i,
    output logic signed [TBL_W-1:0] sin_a,
    output logic signed [TBL_W-1:0] cos_a,
    output logic signed [TBL_W-1:0] sin_b,
    output logic signed [TBL_W-1:0] cos_b,
    output logic                    vld_o
);
    localparam int FINE_W = PH_W - COARSE_W;
    localparam int NC     = 1 << COARSE_W;
    localparam int NF     = 1 << FINE_W;
    localparam int NPH    = 1 << PH_W;
    localparam int SCALE  = 1 << (TBL_W - 2);

    logic signed [TBL_W-1:0] c_sin [NC];
    logic signed [TBL_W-1:0] c_cos [NC];
    logic signed [TBL_W-1:0] f_sin [NF];
    logic signed [TBL_W-1:0] f_cos [NF];

    // Coarse angles step by 2*pi/NC, fine angles by 2*pi/NPH
    for (genvar k = 0; k < NC; k++) begin : g_coarse
        assign c_sin[k] = TBL_W'(trig_code(k, NC, 1'b0, SCALE));
        assign c_cos[k] = TBL_W'(trig_code(k, NC, 1'b1, SCALE));
    end
    for (genvar j = 0; j < NF; j++) begin : g_fine
        assign f_sin[j] = TBL_W'(trig_code(j, NPH, 1'b0, SCALE));
        assign f_cos[j] = TBL_W'(trig_code(j, NPH, 1'b1, SCALE));
    end

    logic [COARSE_W-1:0] a_idx;
    logic [FINE_W-1:0]   b_idx;
    assign a_idx = phase_i[PH_W-1 -: COARSE_W];
    assign b_idx = phase_i[FINE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_a <= '0;
            cos_a <= '0;
            sin_b <= '0;
            cos_b <= '0;
            vld_o <= 1'b0;
        end else if (en) begin
            sin_a <= c_sin[a_idx];
            cos_a <= c_cos[a_idx];
            sin_b <= f_sin[b_idx];
            cos_b <= f_cos[b_idx];
            vld_o <= vld_i;
        end
    end

endmodule

// File: rtl/nco_sin_combine.sv
module nco_sin_combine #(
    parameter int TBL_W = 16,
    parameter int OUT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [TBL_W-1:0] sin_a,
    input  logic signed [TBL_W-1:0] cos_a,
    input  logic signed [TBL_W-1:0] sin_b,
    input  logic signed [TBL_W-1:0] cos_b,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    valid_o
);
    localparam int PROD_W = 2 * TBL_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int FRAC   = 2 * (TBL_W - 2) - (OUT_W - 1);
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -(SUM_W'(1) << (OUT_W - 1));

    logic signed [PROD_W-1:0] p_ab;
    logic signed [PROD_W-1:0] p_ba;
    logic                     v3;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  rnd;
    logic signed [OUT_W-1:0]  clamped;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ab <= '0;
            p_ba <= '0;
            v3   <= 1'b0;
        end else if (en) begin
            p_ab <= PROD_W'(sin_a) * PROD_W'(cos_b);
            p_ba <= PROD_W'(cos_a) * PROD_W'(sin_b);
            v3   <= vld_i;
        end
    end

    always_comb begin
        sum = SUM_W'(p_ab) + SUM_W'(p_ba);
        rnd = (sum + HALF) >>> FRAC;
        if (rnd > MAXV) begin
            clamped = OUT_W'(MAXV);
        end else if (rnd < MINV) begin
            clamped = OUT_W'(MINV);
        end else begin
            clamped = OUT_W'(rnd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= en & v3;
            if (en) begin
                sample_o <= clamped;
            end
        end
    end

    assert_no_wrap_pos_R4: assert property (@(posedge clk) disable iff (rst)
        (en && v3 && sum > 0) |=> !sample_o[OUT_W-1]);

    assert_no_wrap_neg_R4: assert property (@(posedge clk) disable iff (rst)
        (en && v3 && sum < 0) |=> (sample_o[OUT_W-1] || sample_o == '0));

endmodule

// File: rtl/nco_dithered.sv
module nco_dithered #(
    parameter int ACC_W    = 32,
    parameter int PH_W     = 12,
    parameter int COARSE_W = 6,
    parameter int TBL_W    = 16,
    parameter int OUT_W    = 13,
    parameter int DITHER_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic [ACC_W-1:0]        phase_inc_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    valid_o
);
    logic [DITHER_W-1:0]     dither;
    logic [PH_W-1:0]         phase_q;
    logic                    vld1;
    logic signed [TBL_W-1:0] sin_a;
    logic signed [TBL_W-1:0] cos_a;
    logic signed [TBL_W-1:0] sin_b;
    logic signed [TBL_W-1:0] cos_b;
    logic                    vld2;

    nco_dither_lfsr #(.OUT_W(DITHER_W)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .dither_o (dither)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .DITHER_W(DITHER_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .inc     (phase_inc_i),
        .dither  (dither),
        .phase_o (phase_q),
        .vld_o   (vld1)
    );

    nco_trig_tables #(.PH_W(PH_W), .COARSE_W(COARSE_W), .TBL_W(TBL_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .phase_i (phase_q),
        .vld_i   (vld1),
        .sin_a   (sin_a),
        .cos_a   (cos_a),
        .sin_b   (sin_b),
        .cos_b   (cos_b),
        .vld_o   (vld2)
    );

    nco_sin_combine #(.TBL_W(TBL_W), .OUT_W(OUT_W)) u_comb (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .sin_a    (sin_a),
        .cos_a    (cos_a),
        .sin_b    (sin_b),
        .cos_b    (cos_b),
        .vld_i    (vld2),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    assert_valid_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(en_i) |-> !valid_o);

    assert_sample_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(en_i) |-> $stable(sample_o));

endmodule

// File: tb/test_nco_dithered.sv
module test_nco_dithered;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en_i = 1'b0;
    logic [31:0]        phase_inc_i = '0;
    logic signed [12:0] sample_o;
    logic               valid_o;

    int n_checks = 0;
    int n_bad    = 0;

    always #10ns clk = ~clk;

    nco_dithered i_nco_dithered (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .phase_inc_i (phase_inc_i),
        .sample_o    (sample_o),
        .valid_o     (valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ideal(input longint idx, input logic [31:0] inc);
        longint ph;
        real v;
        int r;
        ph = (idx * longint'(inc)) & 64'hFFFF_FFFF;
        v  = 4096.0 * $sin(6.283185307179586 * real'(ph) / 4294967296.0);
        r  = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        if (r > 4095) r = 4095;
        if (r < -4096) r = -4096;
        return r;
    endfunction

    function automatic int quarter(input longint idx, input bit backward);
        int q;
        q = int'(idx % 4);
        if (backward) q = (4 - q) % 4;
        case (q)
            0: return 0;
            1: return 4095;
            2: return 0;
            default: return -4096;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        en_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
        check(sample_o == 0, "R1 sample in reset", int'(sample_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0 && sample_o == 0, "R1 after reset", int'(sample_o), 0);
    endtask

    // mode 0: tolerance vs ideal (R3); 1: exact forward quarters; 2: exact backward quarters
    task automatic run(input logic [31:0] inc, input int cycles, input int en_pct, input int mode);
        int     n_en = 0;
        longint idx  = 0;
        logic signed [12:0] last;
        do_reset();
        phase_inc_i = inc;
        last = sample_o;
        for (int c = 0; c < cycles + 6; c++) begin
            bit e;
            e = (c < cycles) && (($urandom % 100) < en_pct);
            en_i = e;
            @(negedge clk);
            if (e) n_en++;
            // R5/R6/R8: valid exactly after enabled edges once pipeline holds 4 stages
            check(valid_o == (e && n_en >= 4), e ? "R8 valid per enabled edge" : "R6 valid low when disabled",
                  int'(valid_o), int'(e && n_en >= 4));
            if (!e) begin
                check(sample_o == last, "R6 sample holds", int'(sample_o), int'(last));
            end
            if (valid_o) begin
                int exp;
                if (mode == 0) begin
                    exp = ideal(idx, inc);
                    check((int'(sample_o) - exp) <= 10 && (exp - int'(sample_o)) <= 10,
                          "R3 sample near ideal", int'(sample_o), exp);
                end else begin
                    exp = quarter(idx, mode == 2);
                    check(int'(sample_o) == exp, mode == 2 ? "R2 wrap backward" : "R4 exact quarter",
                          int'(sample_o), exp);
                end
                idx++;
            end
            last = sample_o;
        end
        // R5: count of samples after N enabled edges is N-3
        check(idx == ((n_en >= 4) ? n_en - 3 : 0), "R5 sample count", int'(idx),
              (n_en >= 4) ? n_en - 3 : 0);
    endtask

    initial begin
        #(20ns * 150000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R4: quarter turn, continuous then stalled enable
        run(32'h4000_0000, 40, 100, 1);
        run(32'h4000_0000, 60, 60, 1);
        // R2: wrap through a backward step
        run(32'hC000_0000, 40, 100, 2);
        // R5: too few enabled edges gives no sample
        run(32'h0100_0000, 3, 100, 0);
        // R3: tones near 1 MHz and 10 MHz at the nominal rate
        run(32'd42949673, 300, 100, 0);
        run(32'd429496730, 200, 80, 0);
        // R3: random steps with random enable
        for (int k = 0; k < 6; k++) begin
            run($urandom, 150, 70, 0);
        end
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule